// File: doc/BRIEF.md
# Segmented Address Translation Walker

The walker turns a logical address, made of a 16-bit selector and a 32-bit offset, into a linear address. It splits the selector into a table index, a table-select flag and a requested privilege level. From that it locates an 8-byte descriptor either in the global table, whose base and byte limit arrive on input ports, or in the local table currently named by a second selector input. It reads that descriptor as two 32-bit words over a memory read port, adds the segment base to the offset, and checks the requester's privilege against the descriptor.

A local-table access takes two levels. The walker first uses the index of the local-table selector to fetch that table's own descriptor from the global table. This gives the local table's base and limit. It then fetches the target descriptor from the local table. A request that is refused ends with a fault flag and a two-bit cause code in place of an address. One request is handled at a time: a request is accepted only while the walker is idle, and each result is presented for exactly one cycle.

Top module: `seg_xlate_walker`

## Requirements
- R1: The selector is decoded as index = bits 15:3, table select = bit 2 (0 = global, 1 = local), RPL = bits 1:0. The descriptor sits at table base + index*8. The global base, global limit and local-table selector are taken in the cycle the request is accepted, and later changes to them do not affect that request.
- R2: The linear address is the segment base plus the offset, modulo 2^32.
- R3: With table select 1, the index in bits 15:3 of `ltab_sel` picks a descriptor in the global table, and that descriptor's base and limit define the local table. The target descriptor is then read at local base + index*8. Changing `ltab_sel` switches to another local table.
- R4: Descriptor layout, with the low word at the descriptor address and the high word at +4. Base[15:0] = low[31:16], base[23:16] = high[7:0], base[31:24] = high[31:24]. Limit[15:0] = low[15:0], limit[19:16] = high[19:16]. DPL = high[14:13], which is descriptor bits 46:45.
- R5: If index*8+7 exceeds `gtab_limit` for the global-table descriptor being looked up (the target for select 0, or the local-table descriptor for select 1), the walker faults with code 1. It does this without any memory read, and the response comes one cycle after acceptance.
- R6: If index*8+7 of the target exceeds the local table's limit, the walker faults with code 2. Only the two reads of the local-table descriptor are made.
- R7: If max(CPL, RPL) > DPL of the target, the walker faults with code 3. Equality is allowed. Code 0 means no fault. Every faulting response carries a linear address of 0.
- R8: `req_ready` is high only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Requests raised while busy are ignored. `rsp_valid` is high for exactly one cycle per accepted request.
- R9: Counted from the accepting edge, `rsp_valid` rises in cycle 4 for a global-table walk and in cycle 7 for a local-table walk. A code-2 fault also arrives in cycle 4.
- R10: The memory port issues reads in pairs on consecutive cycles, at the descriptor address and then at the address +4. Data is expected one cycle after each read. No read is issued while idle. After reset the walker is idle with `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_sel | input | 16 | Selector of the logical address |
| req_off | input | 32 | Offset of the logical address |
| req_cpl | input | 2 | Current privilege level of the requester |
| gtab_base | input | 32 | Global descriptor table base address |
| gtab_limit | input | 16 | Global descriptor table byte limit |
| ltab_sel | input | 16 | Selector naming the current local table |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| rsp_valid | output | 1 | Result valid (one-cycle pulse) |
| rsp_lin | output | 32 | Linear address (0 on a fault) |
| rsp_fault | output | 1 | Translation refused |
| rsp_fcode | output | 2 | Fault cause: 0 none, 1 global limit, 2 local limit, 3 privilege |

## Verification
The bench builds the walker with its default parameters: 16-bit selectors, 32-bit offsets and linear addresses, a 16-bit global limit, a 20-bit local limit and the privilege check enabled. With these values a small global limit of 3Fh makes both the last legal index and the first illegal one reachable. A 20-bit limit field is loaded into the local-table descriptors, and a base near 2^32 can be set to exercise the modulo wrap. With the privilege check enabled, every CPL/RPL/DPL ordering produces an observable fault code, in both the one-level and the two-level walk.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int BASE_W   = 32;
   localparam int DLIM_W   = 20;
   localparam int DESC_SH  = 3;

   typedef enum logic [1:0] {
      FC_NONE = 2'd0,
      FC_GTAB = 2'd1,
      FC_LTAB = 2'd2,
      FC_PRIV = 2'd3
   } fcode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_LO,
      ST_RD_HI,
      ST_EVAL,
      ST_RESP
   } walk_st_e;

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic [DLIM_W-1:0] limit;
      logic [1:0]        dpl;
   } desc_t;

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
   import seg_xlate_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] word_lo,
   input  logic [DATA_W-1:0] word_hi,
   output desc_t             dsc
);
   logic unused_attr;

   always_comb begin
      dsc.base  = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
      dsc.limit = {word_hi[19:16], word_lo[15:0]};
      dsc.dpl   = word_hi[14:13];
   end

   assign unused_attr = ^{word_hi[23:20], word_hi[15], word_hi[12:8]};
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
   parameter int IDX_W = 13,
   parameter int LIM_W = 16
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [LIM_W-1:0] limit,
   output logic             over
);
   localparam int END_W = IDX_W + 3;
   localparam int CMP_W = (END_W > LIM_W) ? END_W : LIM_W;

   logic [CMP_W-1:0] last_byte;
   logic [CMP_W-1:0] lim_ext;

   assign last_byte = CMP_W'({idx, 3'b111});
   assign lim_ext   = CMP_W'(limit);
   assign over      = last_byte > lim_ext;
endmodule

// File: rtl/seg_priv_chk.sv
module seg_priv_chk #(
   parameter bit PRIV_CHECK = 1'b1
) (
   input  logic [1:0] cpl,
   input  logic [1:0] rpl,
   input  logic [1:0] dpl,
   output logic       deny
);
   generate
      if (PRIV_CHECK) begin : g_on
         logic [1:0] eff;
         assign eff  = (cpl > rpl) ? cpl : rpl;
         assign deny = eff > dpl;
      end else begin : g_off
         logic unused_lvls;
         assign unused_lvls = ^{cpl, rpl, dpl};
         assign deny        = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/seg_xlate_walker.sv
module seg_xlate_walker
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W      = 16,
   parameter int OFF_W      = 32,
   parameter int LIN_W      = 32,
   parameter int GLIM_W     = 16,
   parameter int LLIM_W     = 20,
   parameter int DATA_W     = 32,
   parameter bit PRIV_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_cpl,
   input  logic [BASE_W-1:0] gtab_base,
   input  logic [GLIM_W-1:0] gtab_limit,
   input  logic [SEL_W-1:0]  ltab_sel,
   output logic              mem_rd_en,
   output logic [BASE_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              rsp_valid,
   output logic [LIN_W-1:0]  rsp_lin,
   output logic              rsp_fault,
   output logic [1:0]        rsp_fcode
);
   localparam int IDX_W = SEL_W - 3;

   if (DATA_W != 32) begin : g_bad_data
      $error("seg_xlate_walker: descriptor layout needs DATA_W == 32");
   end
   if (SEL_W < 4) begin : g_bad_sel
      $error("seg_xlate_walker: SEL_W must leave room for an index");
   end
   if (LIN_W < BASE_W || OFF_W > LIN_W) begin : g_bad_lin
      $error("seg_xlate_walker: LIN_W must cover the base and the offset");
   end
   if (LLIM_W < 1 || LLIM_W > DLIM_W) begin : g_bad_llim
      $error("seg_xlate_walker: LLIM_W out of range");
   end

   walk_st_e          st;
   logic [IDX_W-1:0]  idx_q;
   logic [1:0]        rpl_q;
   logic [1:0]        cpl_q;
   logic [OFF_W-1:0]  off_q;
   logic              lvl_q;
   logic [BASE_W-1:0] addr_q;
   logic [DATA_W-1:0] lo_q;

   // selector fields of the incoming request
   logic [IDX_W-1:0]  req_idx;
   logic              req_ti;
   logic [IDX_W-1:0]  ltab_idx;
   logic [IDX_W-1:0]  g_idx;
   logic              unused_lsel;

   assign req_idx     = req_sel[SEL_W-1:3];
   assign req_ti      = req_sel[2];
   assign ltab_idx    = ltab_sel[SEL_W-1:3];
   assign g_idx       = req_ti ? ltab_idx : req_idx;
   assign unused_lsel = ^ltab_sel[2:0];

   logic  g_over;
   logic  l_over;
   logic  deny;
   desc_t dsc;

   seg_limit_chk #(.IDX_W(IDX_W), .LIM_W(GLIM_W)) u_glim (
      .idx   (g_idx),
      .limit (gtab_limit),
      .over  (g_over)
   );

   seg_desc_unpack #(.DATA_W(DATA_W)) u_unpack (
      .word_lo (lo_q),
      .word_hi (mem_rd_data),
      .dsc     (dsc)
   );

   seg_limit_chk #(.IDX_W(IDX_W), .LIM_W(LLIM_W)) u_llim (
      .idx   (idx_q),
      .limit (dsc.limit[LLIM_W-1:0]),
      .over  (l_over)
   );

   seg_priv_chk #(.PRIV_CHECK(PRIV_CHECK)) u_priv (
      .cpl  (cpl_q),
      .rpl  (rpl_q),
      .dpl  (dsc.dpl),
      .deny (deny)
   );

   logic [LIN_W-1:0] lin_sum;
   assign lin_sum = LIN_W'(dsc.base) + LIN_W'(off_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx_q     <= '0;
         rpl_q     <= '0;
         cpl_q     <= '0;
         off_q     <= '0;
         lvl_q     <= 1'b0;
         addr_q    <= '0;
         lo_q      <= '0;
         rsp_lin   <= '0;
         rsp_fault <= 1'b0;
         rsp_fcode <= FC_NONE;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  idx_q  <= req_idx;
                  rpl_q  <= req_sel[1:0];
                  cpl_q  <= req_cpl;
                  off_q  <= req_off;
                  lvl_q  <= req_ti;
                  addr_q <= gtab_base + BASE_W'({g_idx, 3'b000});
                  if (g_over) begin
                     rsp_fault <= 1'b1;
                     rsp_fcode <= FC_GTAB;
                     rsp_lin   <= '0;
                     st        <= ST_RESP;
                  end else begin
                     st <= ST_RD_LO;
                  end
               end
            end
            ST_RD_LO: st <= ST_RD_HI;
            ST_RD_HI: begin
               lo_q <= mem_rd_data;
               st   <= ST_EVAL;
            end
            ST_EVAL: begin
               if (lvl_q) begin
                  lvl_q  <= 1'b0;
                  addr_q <= dsc.base + BASE_W'({idx_q, 3'b000});
                  if (l_over) begin
                     rsp_fault <= 1'b1;
                     rsp_fcode <= FC_LTAB;
                     rsp_lin   <= '0;
                     st        <= ST_RESP;
                  end else begin
                     st <= ST_RD_LO;
                  end
               end else begin
                  rsp_fault <= deny;
                  rsp_fcode <= deny ? FC_PRIV : FC_NONE;
                  rsp_lin   <= deny ? '0 : lin_sum;
                  st        <= ST_RESP;
               end
            end
            ST_RESP: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (st == ST_IDLE);
   assign rsp_valid   = (st == ST_RESP);
   assign mem_rd_en   = (st == ST_RD_LO) || (st == ST_RD_HI);
   assign mem_rd_addr = (st == ST_RD_HI) ? addr_q + BASE_W'(4) : addr_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int LIN_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             mem_rd_en,
   input logic [31:0]      mem_rd_addr,
   input logic             rsp_valid,
   input logic             rsp_fault,
   input logic [1:0]       rsp_fcode,
   input logic [LIN_W-1:0] rsp_lin
);
   // R8: a result is never shown while the walker reports idle
   a_r8_busy_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R8: result pulse lasts one cycle
   a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R8: an accepted request makes the walker busy
   a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10: no memory traffic while idle
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_en);

   // R10: second read of a pair follows at address + 4
   a_r10_pair_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_en) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + 32'd4));

   // R10: reads come in pairs, never three in a row
   a_r10_pair_len: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);

   // R7: a refused translation carries address zero
   a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_lin == '0));

   // R5: fault flag and cause code agree
   a_r5_code_match: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_fcode != 2'd0)));
endmodule

bind seg_xlate_walker seg_xlate_chk #(.LIN_W(LIN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .rsp_valid   (rsp_valid),
   .rsp_fault   (rsp_fault),
   .rsp_fcode   (rsp_fcode),
   .rsp_lin     (rsp_lin)
);

// File: tb/sim_seg_xlate_walker.sv
module sim_seg_xlate_walker;
   // 20-unit period: 50 MHz with 1 ns units
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_sel = '0;
   logic [31:0] req_off = '0;
   logic [1:0]  req_cpl = '0;
   logic [31:0] gtab_base = '0;
   logic [15:0] gtab_limit = '0;
   logic [15:0] ltab_sel = '0;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data = '0;
   logic        rsp_valid;
   logic [31:0] rsp_lin;
   logic        rsp_fault;
   logic [1:0]  rsp_fcode;

   logic [31:0] mem [0:255];
   int n_chk = 0;
   int n_err = 0;
   int rd_cnt = 0;
   bit done = 1'b0;

   seg_xlate_walker u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sel(req_sel), .req_off(req_off), .req_cpl(req_cpl),
      .gtab_base(gtab_base), .gtab_limit(gtab_limit), .ltab_sel(ltab_sel),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_lin(rsp_lin), .rsp_fault(rsp_fault), .rsp_fcode(rsp_fcode)
   );

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= mem[mem_rd_addr[9:2]];
         rd_cnt      <= rd_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input int addr, input logic [31:0] base, input logic [19:0] lim,
                           input logic [1:0] dpl);
      mem[addr >> 2]       = {base[15:0], lim[15:0]};
      mem[(addr >> 2) + 1] = {base[31:24], 4'h0, lim[19:16], 1'b1, dpl, 5'h00, base[23:16]};
   endtask

   task automatic walk(input logic [15:0] sel, input logic [31:0] off, input logic [1:0] cpl,
                       output logic [31:0] lin, output logic flt, output logic [1:0] fc,
                       output int lat, output int nrd);
      int r0;
      @(negedge clk);
      chk("R8 ready before request", 32'(req_ready), 32'd1);
      r0 = rd_cnt;
      req_sel = sel; req_off = off; req_cpl = cpl; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      lin = rsp_lin; flt = rsp_fault; fc = rsp_fcode; nrd = rd_cnt - r0;
      @(negedge clk);
      chk("R8 response is one cycle", 32'(rsp_valid), 32'd0);
   endtask

   task automatic expect_ok(input string tag, input logic [15:0] sel, input logic [31:0] off,
                            input logic [1:0] cpl, input logic [31:0] exp_lin,
                            input int exp_lat, input int exp_rd);
      logic [31:0] lin; logic flt; logic [1:0] fc; int lat; int nrd;
      walk(sel, off, cpl, lin, flt, fc, lat, nrd);
      chk({tag, " lin"}, lin, exp_lin);
      chk({tag, " fault"}, {30'd0, fc} | 32'(flt), 32'd0);
      chk({tag, " R9 latency"}, 32'(lat), 32'(exp_lat));
      chk({tag, " R10 reads"}, 32'(nrd), 32'(exp_rd));
   endtask

   task automatic expect_fault(input string tag, input logic [15:0] sel, input logic [31:0] off,
                               input logic [1:0] cpl, input logic [1:0] exp_fc,
                               input int exp_lat, input int exp_rd);
      logic [31:0] lin; logic flt; logic [1:0] fc; int lat; int nrd;
      walk(sel, off, cpl, lin, flt, fc, lat, nrd);
      chk({tag, " flag"}, 32'(flt), 32'd1);
      chk({tag, " code"}, 32'(fc), 32'(exp_fc));
      chk({tag, " R7 zero lin"}, lin, 32'd0);
      chk({tag, " R9 latency"}, 32'(lat), 32'(exp_lat));
      chk({tag, " R10 reads"}, 32'(nrd), 32'(exp_rd));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 reset ready", 32'(req_ready), 32'd1);
      chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R10 reset mem_rd_en", 32'(mem_rd_en), 32'd0);
   endtask

   task automatic t_global();
      // sel 21h: index 4, global, RPL 1; DPL 2
      expect_ok("R1 R2 sel 21h", 16'h0021, 32'h1234_5678, 2'd0, 32'h2345_6789, 4, 2);
      expect_ok("R4 base bytes", 16'h000B, 32'h0, 2'd3, 32'hA1B2_C3D4, 4, 2);
      expect_ok("R2 wrap", 16'h0013, 32'h0000_0020, 2'd3, 32'h0000_0010, 4, 2);
   endtask

   task automatic t_local();
      ltab_sel = 16'h0028;
      expect_ok("R3 sel 1Ch table A", 16'h001C, 32'h1234_5678, 2'd0, 32'h2345_6789, 7, 4);
      ltab_sel = 16'h0030;
      expect_ok("R3 sel 1Fh table B", 16'h001F, 32'h0000_1234, 2'd3, 32'h0BAD_1234, 7, 4);
      ltab_sel = 16'h0028;
   endtask

   task automatic t_glimit();
      expect_ok("R5 last legal index", 16'h0038, 32'h0, 2'd0, 32'h00C0_FFEE, 4, 2);
      expect_fault("R5 index past limit", 16'h0040, 32'h0, 2'd0, 2'd1, 1, 0);
      gtab_limit = 16'h003E;
      expect_fault("R5 limit one short", 16'h0038, 32'h0, 2'd0, 2'd1, 1, 0);
      gtab_limit = 16'h0027;
      expect_fault("R5 local table past limit", 16'h001C, 32'h0, 2'd0, 2'd1, 1, 0);
      gtab_limit = 16'h003F;
   endtask

   task automatic t_llimit();
      expect_fault("R6 local index past limit", 16'h0024, 32'h0, 2'd0, 2'd2, 4, 2);
   endtask

   task automatic t_priv();
      expect_fault("R7 cpl above dpl", 16'h0018, 32'h0, 2'd2, 2'd3, 4, 2);
      expect_fault("R7 rpl above dpl", 16'h001A, 32'h0, 2'd0, 2'd3, 4, 2);
      expect_ok("R7 equal levels", 16'h0019, 32'h0000_0042, 2'd1, 32'h0000_5042, 4, 2);
      expect_fault("R7 cpl 3 on dpl 2", 16'h0021, 32'h0, 2'd3, 2'd3, 4, 2);
      expect_fault("R7 R3 local target", 16'h001D, 32'h0, 2'd0, 2'd3, 7, 4);
   endtask

   task automatic t_busy();
      int seen;
      @(negedge clk);
      req_sel = 16'h0021; req_off = 32'h0; req_cpl = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      chk("R8 busy after accept", 32'(req_ready), 32'd0);
      req_sel = 16'h0040;
      gtab_base = 32'h0000_0000;
      while (!rsp_valid) @(negedge clk);
      req_valid = 1'b0;
      chk("R8 R1 busy request ignored lin", rsp_lin, 32'h1111_1111);
      chk("R8 R1 busy request ignored fault", 32'(rsp_fault), 32'd0);
      gtab_base = 32'h0000_0100;
      seen = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (rsp_valid) seen++;
      end
      chk("R8 single response per accept", 32'(seen), 32'd0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      put_desc(32'h108, 32'hA1B2_C3D4, 20'hFFFFF, 2'd3);
      put_desc(32'h110, 32'hFFFF_FFF0, 20'hFFFFF, 2'd3);
      put_desc(32'h118, 32'h0000_5000, 20'hFFFFF, 2'd1);
      put_desc(32'h120, 32'h1111_1111, 20'hFFFFF, 2'd2);
      put_desc(32'h128, 32'h0000_0200, 20'h0001F, 2'd0);
      put_desc(32'h130, 32'h0000_0280, 20'h0001F, 2'd0);
      put_desc(32'h138, 32'h00C0_FFEE, 20'hFFFFF, 2'd3);
      put_desc(32'h218, 32'h1111_1111, 20'hFFFFF, 2'd0);
      put_desc(32'h298, 32'h0BAD_0000, 20'hFFFFF, 2'd3);
      gtab_base  = 32'h0000_0100;
      gtab_limit = 16'h003F;
      ltab_sel   = 16'h0028;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_global();
      t_local();
      t_glimit();
      t_llimit();
      t_priv();
      t_busy();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule